// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic use an external, unclocked static RAM of 256K bytes. The user side has a single-request handshake. A request carries a read/write flag, an 18-bit byte address and, for writes, one data byte. The block accepts the request when both `reqValid` and `reqReady` are high. It then runs the memory cycle on its own and ends it with a one-cycle `rspDone` pulse. For a read, that pulse comes with the byte fetched from the memory.

On the memory side the block drives the address lines and two chip selects. The first chip select is active low and the second is active high. It also drives active-low output-enable and write-enable lines and a shared 8-bit tri-state data bus. Every timing limit of the memory is given in nanoseconds as a parameter, next to the clock period. The block turns each limit into a whole number of cycles, rounding up, with a minimum of one. The controller holds its data drivers off until any read data that may still be on the bus has had time to fade.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and right after it, the first chip select is high, the second chip select is low, output enable and write enable are both high (inactive), `reqReady` is 1 and `rspDone` is 0.
- R2: `reqReady` is high only while the block is idle. It drops in the cycle after a request is accepted and stays low until the cycle in which `rspDone` is asserted.
- R3: A read keeps the chip selected, output enable low and write enable high for N_RD cycles. N_RD is the largest of the cycle counts for the read cycle time (55 ns), the address access time (55 ns) and the output-enable access time (25 ns). The bus is registered at the last of these cycles. `rspData` and a one-cycle `rspDone` pulse appear exactly N_RD cycles after the accepting edge.
- R4: Write enable goes low only while the chip is selected and output enable is high. Each low pulse lasts exactly ceil(40 ns / period) cycles.
- R5: The address and the write data stay stable for the whole write. Together, setup and strobe last at least the address-to-write-end time (45 ns), the select-to-write-end time (45 ns) and the data-to-write-end time (25 ns). Address and data are still held in the cycle after write enable rises.
- R6: A write starting from a clean idle gives `rspDone` after N_SET + N_PWE + N_REC cycles. Here N_SET = max(1, N_PRE − N_PWE) and N_PRE is the largest of the three write-end setup counts. N_REC is chosen so that the total is at least ceil(55 ns / period).
- R7: The controller never drives the data bus while output enable is low, and output enable stays high for the whole of any write.
- R8: A write can follow a read before the output-disable time (20 ns) has passed since output enable rose. In that case the block waits with output enable high and the bus released. The memory is reselected for the write no earlier than N_HZ cycles after that rise.
- R9: Whenever the block is idle, the memory is deselected (first chip select high, second chip select low) and both strobes are inactive.
- R10: A read of a location returns the byte of the last completed write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address |
| reqWdata | input | 8 | Byte to write |
| rspData | output | 8 | Byte read, valid with rspDone after a read |
| rspDone | output | 1 | One-cycle completion pulse |
| memAddr | output | 18 | Memory address lines |
| memCs1N | output | 1 | Memory select, active low |
| memCs2 | output | 1 | Memory select, active high |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDq | inout | 8 | Bidirectional memory data bus |

## Verification
With a 4 ns clock, a read reports 14 cycles after its accepting edge. A write from a clean idle also reports after 14 cycles (2 setup, 10 strobe and 2 recovery). A write issued right after a read may take up to N_HZ + 1 more cycles. The bench counts falling edges from the accepting edge and compares the count with these figures exactly, or for post-read writes with the allowed range. A model on the memory pins samples on falling edges. It counts strobe width, address and data stability before write end, and the time from output-enable rise to reselection. It returns inverted data until the access time has elapsed, so a read captured early comes back wrong.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_STROBE,
    ST_WR_RECOVER,
    ST_TURN
  } stateT;

  // memory-pin intent, active high internally
  typedef struct packed {
    logic sel;
    logic oeLow;
    logic weLow;
    logic drive;
  } pinCtrlT;

  typedef struct packed {
    pinCtrlT pins;
    logic    load;
    logic    capture;
    logic    finish;
  } ctrlT;

  function automatic int cycFromNs(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_DOE  = 25,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_SD   = 25,
  parameter int T_AW   = 45,
  parameter int T_SCS  = 45,
  parameter int T_HZOE = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output ctrlT ctrl
);

  localparam int N_RD    = maxOf(maxOf(cycFromNs(T_AA, CLK_NS), cycFromNs(T_RC, CLK_NS)),
                                 cycFromNs(T_DOE, CLK_NS));
  localparam int N_PWE   = cycFromNs(T_PWE, CLK_NS);
  localparam int N_PRE   = maxOf(maxOf(cycFromNs(T_AW, CLK_NS), cycFromNs(T_SCS, CLK_NS)),
                                 cycFromNs(T_SD, CLK_NS));
  localparam int N_SET   = maxOf(1, N_PRE - N_PWE);
  localparam int N_REC   = maxOf(1, cycFromNs(T_WC, CLK_NS) - N_SET - N_PWE);
  localparam int N_HZ    = cycFromNs(T_HZOE, CLK_NS);
  localparam int CNT_MAX = maxOf(maxOf(N_RD, N_PWE), maxOf(N_SET, N_REC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int HZ_W    = $clog2(N_HZ + 1);

  stateT            state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [HZ_W-1:0]  hzLeft;
  pinCtrlT          pinsQ;

  function automatic pinCtrlT pinsFor(input stateT s);
    pinCtrlT p;
    p = '0;
    unique case (s)
      ST_RD_ACCESS:  begin p.sel = 1'b1; p.oeLow = 1'b1; end
      ST_WR_SETUP:   begin p.sel = 1'b1; p.drive = 1'b1; end
      ST_WR_STROBE:  begin p.sel = 1'b1; p.drive = 1'b1; p.weLow = 1'b1; end
      ST_WR_RECOVER: begin p.sel = 1'b1; p.drive = 1'b1; end
      default:       p = '0;
    endcase
    return p;
  endfunction

  always_comb begin
    stateNext = state;
    cntNext   = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            if (hzLeft != '0) begin
              stateNext = ST_TURN;
            end else begin
              stateNext = ST_WR_SETUP;
              cntNext   = CNT_W'(N_SET - 1);
            end
          end else begin
            stateNext = ST_RD_ACCESS;
            cntNext   = CNT_W'(N_RD - 1);
          end
        end
      end
      ST_RD_ACCESS:  if (cnt == '0) stateNext = ST_RD_CAPTURE;
      ST_RD_CAPTURE: stateNext = ST_IDLE;
      ST_TURN: begin
        if (hzLeft == '0) begin
          stateNext = ST_WR_SETUP;
          cntNext   = CNT_W'(N_SET - 1);
        end
      end
      ST_WR_SETUP: begin
        if (cnt == '0) begin
          stateNext = ST_WR_STROBE;
          cntNext   = CNT_W'(N_PWE - 1);
        end
      end
      ST_WR_STROBE: begin
        if (cnt == '0) begin
          stateNext = ST_WR_RECOVER;
          cntNext   = CNT_W'(N_REC - 1);
        end
      end
      ST_WR_RECOVER: if (cnt == '0) stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      hzLeft <= '0;
      pinsQ  <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      pinsQ <= pinsFor(stateNext);
      if (state == ST_RD_ACCESS && cnt == '0) hzLeft <= HZ_W'(N_HZ);
      else if (hzLeft != '0)                   hzLeft <= hzLeft - 1'b1;
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign ctrl.pins    = pinsQ;
  assign ctrl.load    = (state == ST_IDLE) && reqValid;
  assign ctrl.capture = (state == ST_RD_ACCESS) && (cnt == '0);
  assign ctrl.finish  = ctrl.capture || ((state == ST_WR_RECOVER) && (cnt == '0));

  // R2: accepted request makes the block busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: idle state leaves the memory deselected
  p_idle_deselect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!pinsQ.sel && !pinsQ.weLow && !pinsQ.oeLow));

  // R7: strobes never both active
  p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    pinsQ.weLow |-> !pinsQ.oeLow);

endmodule

// File: rtl/asram_ctrl_dp.sv
`timescale 1ns/1ps
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int N_PWE  = 10,
  parameter int N_HZ   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  localparam int WE_W = $clog2(N_PWE + 2);
  localparam int OE_W = $clog2(N_HZ + 2);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (ctrl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctrl.capture) rdataQ <= dqIn;
      doneQ <= ctrl.finish;
    end
  end

  assign memAddr = addrQ;
  assign memCs1N = !ctrl.pins.sel;
  assign memCs2  = ctrl.pins.sel;
  assign memOeN  = !ctrl.pins.oeLow;
  assign memWeN  = !ctrl.pins.weLow;
  assign dqOut   = wdataQ;
  assign dqOe    = ctrl.pins.drive;
  assign rspData = rdataQ;
  assign rspDone = doneQ;

  // watch counters for the timing assertions
  logic [WE_W-1:0] weLowCnt;
  logic [OE_W-1:0] oeHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= OE_W'(N_HZ + 1);
    end else begin
      if (!memWeN) weLowCnt <= (weLowCnt == WE_W'(N_PWE + 1)) ? weLowCnt : weLowCnt + 1'b1;
      else         weLowCnt <= '0;
      if (!memOeN) oeHighCnt <= '0;
      else         oeHighCnt <= (oeHighCnt == OE_W'(N_HZ + 1)) ? oeHighCnt : oeHighCnt + 1'b1;
    end
  end

  // R4: every strobe lasts the full pulse width
  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= WE_W'(N_PWE)));

  // R4: strobe only with chip selected and outputs off
  p_strobe_selected_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCs1N && memCs2 && memOeN));

  // R5: address frozen while strobe is low
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(memWeN)) |-> $stable(memAddr));

  // R5: write data frozen while driven
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe && $past(dqOe)) |-> $stable(dqOut));

  // R7: no drive while the memory may output
  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> memOeN);

  // R8: drive begins only after the output-disable window
  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> (oeHighCnt >= OE_W'(N_HZ)));

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 4,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_DOE  = 25,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_SD   = 25,
  parameter int T_AW   = 45,
  parameter int T_SCS  = 45,
  parameter int T_HZOE = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memDq
);

  localparam int N_PWE = cycFromNs(T_PWE, CLK_NS);
  localparam int N_HZ  = cycFromNs(T_HZOE, CLK_NS);

  ctrlT              ctrl;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  asram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_DOE(T_DOE), .T_WC(T_WC),
    .T_PWE(T_PWE), .T_SD(T_SD), .T_AW(T_AW), .T_SCS(T_SCS), .T_HZOE(T_HZOE)
  ) i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .ctrl     (ctrl)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PWE(N_PWE), .N_HZ(N_HZ)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .dqIn     (memDq),
    .memAddr  (memAddr),
    .memCs1N  (memCs1N),
    .memCs2   (memCs2),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .rspData  (rspData),
    .rspDone  (rspDone)
  );

  assign memDq = dqOe ? dqOut : {DATA_W{1'bz}};

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  localparam int CLK_NS = 4;
  localparam int T_RC = 55, T_AA = 55, T_DOE = 25, T_WC = 55, T_PWE = 40;
  localparam int T_SD = 25, T_AW = 45, T_SCS = 45, T_HZOE = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(mx(cyc(T_AA), cyc(T_RC)), cyc(T_DOE));
  localparam int E_PWE = cyc(T_PWE);
  localparam int E_SET = mx(1, mx(mx(cyc(T_AW), cyc(T_SCS)), cyc(T_SD)) - E_PWE);
  localparam int E_REC = mx(1, cyc(T_WC) - E_SET - E_PWE);
  localparam int E_WR  = E_SET + E_PWE + E_REC;
  localparam int E_HZ  = cyc(T_HZOE);

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic        reqReady;
  logic [17:0] reqAddr;
  logic [7:0]  reqWdata;
  logic [7:0]  rspData;
  logic        rspDone;
  logic [17:0] memAddr;
  logic        memCs1N, memCs2, memOeN, memWeN;
  wire  [7:0]  memDq;
  logic [7:0]  modelOut;
  logic        modelDrv;

  assign memDq = modelDrv ? modelOut : 8'bz;

  always #2 clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspData(rspData), .rspDone(rspDone), .memAddr(memAddr),
    .memCs1N(memCs1N), .memCs2(memCs2), .memOeN(memOeN), .memWeN(memWeN),
    .memDq(memDq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] modelMem [int];
  logic [7:0] refMem   [int];

  function automatic logic [7:0] rdModel(input logic [17:0] a);
    return modelMem.exists(int'(a)) ? modelMem[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] rdRef(input logic [17:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
  endfunction

  int          readCnt, weCnt, aStable, dStable, oeHighCnt;
  int          lastASt, lastDSt;
  logic [17:0] prevAddr, lastAddr;
  logic [7:0]  prevDq, lastData;
  logic        prevSel, prevWph, wasWeLow, oeBad;

  initial begin
    modelDrv = 1'b0; modelOut = 8'h00;
    readCnt = 0; weCnt = 0; aStable = 0; dStable = 0; oeHighCnt = 1000;
    lastASt = 0; lastDSt = 0; prevAddr = '0; lastAddr = '0; prevDq = '0; lastData = '0;
    prevSel = 1'b0; prevWph = 1'b0; wasWeLow = 1'b0; oeBad = 1'b0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit sel, wph, weLow;
      sel   = !memCs1N && memCs2;
      wph   = sel && memOeN;
      weLow = sel && !memWeN;
      // read side: inverted data until access time is met (R3)
      if (sel && !memOeN && memWeN)
        readCnt = (readCnt > 0 && memAddr == prevAddr) ? readCnt + 1 : 1;
      else
        readCnt = 0;
      modelDrv = sel && !memOeN && memWeN;
      modelOut = (readCnt * CLK_NS >= T_AA) ? rdModel(memAddr) : ~rdModel(memAddr);
      // stability counters
      aStable = sel ? ((prevSel && memAddr == prevAddr) ? aStable + 1 : 1) : 0;
      dStable = wph ? ((prevWph && memDq == prevDq) ? dStable + 1 : 1) : 0;
      // R8: reselect for a write only after the disable window
      if (wph && !prevWph && oeHighCnt < 100)
        check((oeHighCnt - 1) >= E_HZ, "R8 turnaround", oeHighCnt - 1, E_HZ);
      oeHighCnt = memOeN ? ((oeHighCnt < 1000) ? oeHighCnt + 1 : oeHighCnt) : 0;
      // write side
      if (weLow) begin
        weCnt++;
        if (!memOeN) oeBad = 1'b1;
        lastAddr = memAddr; lastData = memDq; lastASt = aStable; lastDSt = dStable;
      end else if (wasWeLow) begin
        check(weCnt * CLK_NS >= T_PWE, "R4 strobe width", weCnt, E_PWE);
        check(lastDSt * CLK_NS >= T_SD, "R5 data setup", lastDSt, cyc(T_SD));
        check(lastASt * CLK_NS >= mx(T_AW, T_SCS), "R5 addr setup", lastASt, cyc(T_AW));
        check(memAddr == lastAddr && memDq == lastData, "R5 hold", int'(memDq), int'(lastData));
        check(!oeBad, "R7 oe high in write", int'(oeBad), 0);
        modelMem[int'(lastAddr)] = lastData;
        weCnt = 0; oeBad = 1'b0;
      end
      wasWeLow = weLow;
      prevSel = sel; prevWph = wph; prevAddr = memAddr; prevDq = memDq;
    end
  end

  // ---------------- stimulus ----------------
  bit lastWasRead = 1'b0;

  task automatic doOp(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int  g, lat;
    bit  busyOk;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    g = 0;
    while (!reqReady && g < 100) begin @(negedge clk); g++; end
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0; busyOk = 1'b1;
    while (!rspDone && lat < 200) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(busyOk, "R2 ready low while busy", int'(busyOk), 1);
    if (!wr) begin
      check(lat == E_RD, "R3 read latency", lat, E_RD);
      check(rspData == rdRef(a), "R10 read data", int'(rspData), int'(rdRef(a)));
    end else begin
      if (lastWasRead)
        check(lat >= E_WR && lat <= E_WR + E_HZ + 1, "R8 write after read latency", lat, E_WR);
      else
        check(lat == E_WR, "R6 write latency", lat, E_WR);
      refMem[int'(a)] = d;
    end
    lastWasRead = !wr;
    @(negedge clk);
    check(!rspDone, "R3 done single pulse", int'(rspDone), 0);
    check(reqReady && memCs1N && !memCs2 && memOeN && memWeN, "R9 idle deselect",
          {reqReady, memCs1N, memCs2, memOeN, memWeN}, 5'b11011);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(memCs1N && !memCs2 && memOeN && memWeN, "R1 pins in reset",
          {memCs1N, memCs2, memOeN, memWeN}, 4'b1011);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspDone, "R1 ready after reset", {reqReady, rspDone}, 2'b10);
    check(memCs1N && !memCs2 && memOeN && memWeN, "R1 pins after reset",
          {memCs1N, memCs2, memOeN, memWeN}, 4'b1011);

    // directed corners
    doOp(1'b1, 18'h00000, 8'hA5);
    doOp(1'b0, 18'h00000, 8'h00);
    doOp(1'b1, 18'h3FFFF, 8'h5A);
    doOp(1'b0, 18'h3FFFF, 8'h00);
    doOp(1'b0, 18'h12345, 8'h00);       // never written
    doOp(1'b1, 18'h00000, 8'h3C);       // write right after read: turnaround
    doOp(1'b0, 18'h00000, 8'h00);
    doOp(1'b1, 18'h00001, 8'hFF);       // back-to-back writes
    doOp(1'b1, 18'h00001, 8'h00);
    doOp(1'b0, 18'h00001, 8'h00);

    // random traffic
    for (int i = 0; i < 150; i++) begin
      bit          wr;
      logic [17:0] a;
      wr = ($urandom % 2) == 1;
      a  = 18'h20000 | 18'($urandom % 16);
      doOp(wr, a, 8'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule